// File: doc/BRIEF.md
# Address-Match Breakpoint Controller

This block is the debug breakpoint unit of an 8-bit microcontroller with a 16-bit address bus. Software loads a 16-bit break address as two byte registers and sets an enable bit. From then on, every valid bus address is compared with the break address. A match latches a break-active flag, and that flag is the break interrupt request. Software can also raise a break with no match at all by writing 1 to the flag. The flag stays set until software writes it back to 0, which the break handler does before it returns.

While the flag is set, the block holds a freeze output that stops the timer counters. It also drives a watchdog-disable output, but only if a separate control bit in an auxiliary register permits it. Registers are reached over a small synchronous bus with a 2-bit select, a write strobe and combinational read data.

Top module: `bkpt_unit`

## Requirements
- R1: Select 1 reads and writes the high byte of the break address and select 2 the low byte. Both read back the last value written. Select 3 is the auxiliary register: bit 7 holds the watchdog-gate bit and bits 6..0 read 0.
- R2: Select 0 is the control register. Bit 7 is the enable bit, bit 6 is the break-active flag, and bits 5..0 always read 0. Writing it loads the enable bit from bit 7 and the flag from bit 6.
- R3: When bus_valid is 1, the enable bit is 1 and bus_addr equals {high byte, low byte} on all 16 bits at a rising edge, the flag reads 1 after that edge.
- R4: A bus address sets nothing when the enable bit is 0 or bus_valid is 0. A mismatch in either byte also sets nothing.
- R5: Writing the control register with bit 6 = 1 sets the flag even without a match, whatever value bit 7 carries.
- R6: The flag holds until the control register is written with bit 6 = 0, which clears it. If a qualified match occurs in the same cycle as that write, the flag stays 1. The match is judged on the enable value held before the write.
- R7: Synchronous reset clears the enable bit, the flag, the watchdog-gate bit and both address bytes, so every register reads 0x00.
- R8: brk_irq and tmr_freeze are both 1 exactly when the flag is 1.
- R9: wdog_off is 1 exactly when the flag is 1 and the watchdog-gate bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Qualifies bus_addr for comparison |
| bus_addr | input | 16 | CPU bus address |
| reg_sel | input | 2 | Register select (0 control, 1 high, 2 low, 3 aux) |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data of the selected register |
| brk_irq | output | 1 | Break interrupt request (level) |
| tmr_freeze | output | 1 | Stops the timer counters during a break |
| wdog_off | output | 1 | Disables the watchdog during a gated break |

## Verification
The bench builds the block with the package defaults: 8-bit data and a 16-bit address. With these values the comparator has two byte lanes. The bench drives addresses that differ from the target in only one lane, so a fault in either lane's compare or in the lane reduction shows up. It also applies a control write and a qualified match in the same cycle, and a forced break with the enable bit clear. Small byte values let a random sweep hit the target address often.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    parameter int unsigned DATA_W = 8;
    parameter int unsigned ADDR_W = 2 * DATA_W;
    parameter int unsigned SEL_W  = 2;

    localparam int unsigned LANES   = ADDR_W / DATA_W;
    localparam int unsigned EN_POS  = DATA_W - 1;
    localparam int unsigned ACT_POS = DATA_W - 2;
    localparam int unsigned WDG_POS = DATA_W - 1;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_AHI  = 2'd1,
        SEL_ALO  = 2'd2,
        SEL_AUX  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              we;
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } reg_wr_t;

    function automatic logic [DATA_W-1:0] ctrl_image(input logic en, input logic act);
        logic [DATA_W-1:0] v;
        v          = '0;
        v[EN_POS]  = en;
        v[ACT_POS] = act;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] aux_image(input logic wdg);
        logic [DATA_W-1:0] v;
        v          = '0;
        v[WDG_POS] = wdg;
        return v;
    endfunction

endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
    import bkpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  reg_wr_t           wr,
    input  logic              act,
    output logic              en,
    output logic              wdg,
    output logic [ADDR_W-1:0] brk_addr,
    output logic [DATA_W-1:0] rdata
);

    logic              en_q;
    logic              wdg_q;
    logic [DATA_W-1:0] hi_q;
    logic [DATA_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            wdg_q <= 1'b0;
            hi_q  <= '0;
            lo_q  <= '0;
        end else if (wr.we) begin
            case (wr.sel)
                SEL_CTRL: en_q  <= wr.data[EN_POS];
                SEL_AHI:  hi_q  <= wr.data;
                SEL_ALO:  lo_q  <= wr.data;
                SEL_AUX:  wdg_q <= wr.data[WDG_POS];
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (wr.sel)
            SEL_CTRL: rdata = ctrl_image(en_q, act);
            SEL_AHI:  rdata = hi_q;
            SEL_ALO:  rdata = lo_q;
            SEL_AUX:  rdata = aux_image(wdg_q);
            default:  rdata = '0;
        endcase
    end

    assign en       = en_q;
    assign wdg      = wdg_q;
    assign brk_addr = {hi_q, lo_q};

    p_addr_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !(wr.we && (wr.sel == SEL_AHI || wr.sel == SEL_ALO)) |=> $stable(brk_addr));

endmodule

// File: rtl/bkpt_cmp.sv
module bkpt_cmp
    import bkpt_pkg::*;
(
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ADDR_W-1:0] brk_addr,
    input  logic              en,
    output logic              hit
);

    logic [LANES-1:0] lane_eq;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (bus_addr[g*DATA_W +: DATA_W] == brk_addr[g*DATA_W +: DATA_W]);
    end

    assign hit = bus_valid & en & (&lane_eq);

    always_comb begin
        if (hit) a_hit_exact_r3: assert (bus_addr == brk_addr);
    end

endmodule

// File: rtl/bkpt_flag.sv
module bkpt_flag
    import bkpt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic ctl_wr,
    input  logic wr_act,
    output logic act
);

    logic act_q;

    always_ff @(posedge clk) begin
        if (rst)
            act_q <= 1'b0;
        else if (ctl_wr)
            act_q <= wr_act | hit;
        else if (hit)
            act_q <= 1'b1;
    end

    assign act = act_q;

    p_hit_sets_r3: assert property (@(posedge clk) disable iff (rst)
        hit |=> act);

    p_no_spurious_r4: assert property (@(posedge clk) disable iff (rst)
        (!act && !hit && !(ctl_wr && wr_act)) |=> !act);

    p_force_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && wr_act) |=> act);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (act && !ctl_wr) |=> act);

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !wr_act && !hit) |=> !act);

endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
    import bkpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              brk_irq,
    output logic              tmr_freeze,
    output logic              wdog_off
);

    reg_wr_t           wr;
    logic              en;
    logic              wdg;
    logic              act;
    logic              hit;
    logic              ctl_wr;
    logic [ADDR_W-1:0] brk_addr;

    assign wr.we   = reg_we;
    assign wr.sel  = reg_sel_e'(reg_sel);
    assign wr.data = reg_wdata;
    assign ctl_wr  = reg_we && (reg_sel_e'(reg_sel) == SEL_CTRL);

    bkpt_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .act      (act),
        .en       (en),
        .wdg      (wdg),
        .brk_addr (brk_addr),
        .rdata    (reg_rdata)
    );

    bkpt_cmp u_cmp (
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .brk_addr  (brk_addr),
        .en        (en),
        .hit       (hit)
    );

    bkpt_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .hit    (hit),
        .ctl_wr (ctl_wr),
        .wr_act (reg_wdata[ACT_POS]),
        .act    (act)
    );

    assign brk_irq    = act;
    assign tmr_freeze = act;
    assign wdog_off   = act & wdg;

    p_irq_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        brk_irq == tmr_freeze);

    p_wdog_gated_r9: assert property (@(posedge clk) disable iff (rst)
        wdog_off |-> (tmr_freeze && wdg));

    p_disabled_r4: assert property (@(posedge clk) disable iff (rst)
        (!en && !brk_irq && !ctl_wr) |=> !brk_irq);

endmodule

// File: tb/sim_bkpt_unit.sv
module sim_bkpt_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_valid;
    logic [15:0] bus_addr;
    logic [1:0]  reg_sel;
    logic        reg_we;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        brk_irq;
    logic        tmr_freeze;
    logic        wdog_off;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit       m_en, m_act, m_wdg;
    bit [7:0] m_hi, m_lo;

    always #(CLK_PERIOD/2) clk = ~clk;

    bkpt_unit u0 (
        .clk        (clk),
        .rst        (rst),
        .bus_valid  (bus_valid),
        .bus_addr   (bus_addr),
        .reg_sel    (reg_sel),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .brk_irq    (brk_irq),
        .tmr_freeze (tmr_freeze),
        .wdog_off   (wdog_off)
    );

    always @(posedge clk) begin
        bit hit;
        if (rst) begin
            m_en = 0; m_act = 0; m_wdg = 0; m_hi = 0; m_lo = 0;
        end else begin
            hit = bus_valid && m_en && (bus_addr == {m_hi, m_lo});
            if (reg_we) begin
                case (reg_sel)
                    2'd0: begin m_en = reg_wdata[7]; m_act = reg_wdata[6] || hit; end
                    2'd1: begin m_hi = reg_wdata; m_act = m_act || hit; end
                    2'd2: begin m_lo = reg_wdata; m_act = m_act || hit; end
                    default: begin m_wdg = reg_wdata[7]; m_act = m_act || hit; end
                endcase
            end else begin
                m_act = m_act || hit;
            end
        end
    end

    task automatic cmp1(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all();
        bit [7:0] exp_rd;
        string    rq;
        case (reg_sel)
            2'd0: begin exp_rd = {m_en, m_act, 6'b0}; rq = "R2"; end
            2'd1: begin exp_rd = m_hi; rq = "R1"; end
            2'd2: begin exp_rd = m_lo; rq = "R1"; end
            default: begin exp_rd = {m_wdg, 7'b0}; rq = "R1"; end
        endcase
        cmp1(rq, "reg_rdata", int'(reg_rdata), int'(exp_rd));
        cmp1("R8", "brk_irq", int'(brk_irq), int'(m_act));
        cmp1("R8", "tmr_freeze", int'(tmr_freeze), int'(m_act));
        cmp1("R9", "wdog_off", int'(wdog_off), int'(m_act && m_wdg));
    endtask

    // one cycle: compare outputs at the falling edge, then drive the next inputs
    task automatic cyc(input bit r, input bit we, input bit [1:0] sel, input bit [7:0] wd,
                       input bit v, input bit [15:0] a);
        @(negedge clk);
        check_all();
        rst = r; reg_we = we; reg_sel = sel; reg_wdata = wd; bus_valid = v; bus_addr = a;
    endtask

    task automatic idle(input bit [1:0] sel);
        cyc(0, 0, sel, 8'h00, 0, 16'h0000);
    endtask

    task automatic wr(input bit [1:0] sel, input bit [7:0] d);
        cyc(0, 1, sel, d, 0, 16'h0000);
    endtask

    task automatic bus(input bit v, input bit [15:0] a);
        cyc(0, 0, 2'd0, 8'h00, v, a);
    endtask

    initial begin
        rst = 1; reg_we = 0; reg_sel = 0; reg_wdata = 0; bus_valid = 0; bus_addr = 0;
        repeat (3) @(posedge clk);
        // R7: every register reads 0x00 after reset
        for (int s = 0; s < 4; s++) cyc(1, 0, 2'(s), 8'h00, 0, 16'h0);
        for (int s = 0; s < 4; s++) idle(2'(s));
        // R1: address bytes and aux readback
        wr(2'd1, 8'h12); wr(2'd2, 8'h34); wr(2'd3, 8'hFF);
        idle(2'd1); idle(2'd2); idle(2'd3);
        // R4: enable clear, match ignored
        bus(1, 16'h1234); idle(2'd0);
        // enable, then mismatches in each lane and an invalid strobe (R4)
        wr(2'd0, 8'h80);
        bus(1, 16'h1235); bus(1, 16'h0234); bus(0, 16'h1234); idle(2'd0);
        // R3: qualified match sets flag one edge later
        bus(1, 16'h1234); idle(2'd0);
        // R6: flag holds
        repeat (4) idle(2'd0);
        wr(2'd0, 8'h80); idle(2'd0);
        // R6: clear write with simultaneous match keeps flag
        cyc(0, 1, 2'd0, 8'h80, 1, 16'h1234); idle(2'd0);
        wr(2'd0, 8'h80); idle(2'd0);
        // R5: forced break with enable clear, watchdog gate off then on (R9)
        wr(2'd3, 8'h00); wr(2'd0, 8'h40); idle(2'd0); idle(2'd3);
        wr(2'd3, 8'h80); idle(2'd0);
        wr(2'd0, 8'h00); idle(2'd0);
        // R7: reset in the middle of a break
        wr(2'd0, 8'hC0); idle(2'd0);
        cyc(1, 0, 2'd0, 8'h00, 0, 16'h0); idle(2'd0); idle(2'd1); idle(2'd3);
        // random sweep near a small target
        wr(2'd1, 8'h01); wr(2'd2, 8'h02); wr(2'd0, 8'h80);
        for (int i = 0; i < 600; i++) begin
            bit [31:0] rv = $urandom;
            bit        we = (rv[3:0] == 4'h0);
            cyc(0, we, rv[5:4], {rv[7:6], 6'b0} | (rv[5:4] != 0 ? {6'b0, rv[9:8]} : 8'h00),
                rv[10], {6'b0, rv[12:11], 6'b0, rv[14:13]});
        end
        idle(2'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule